// File: doc/BRIEF.md
# Multi-line tagged receive silo

This block gathers received characters from sixteen serial receiver lines into one shared first-in first-out store (the silo). The deserializer of each line presents a byte with its parity and framing error bits and pulses a one-cycle strobe. The byte is first caught in a one-deep holding register for that line. A fixed-priority picker then moves one held character per cycle into the silo. The picker always takes the lowest-numbered line that has a character waiting.

Each silo word is tagged with the line it came from and its error status. The top bit is set for a valid word, so the word reads as negative while data remains. The host drains the silo by reading the next-character register until that bit comes back clear. Each such read removes the head entry. A level interrupt tells the host that the silo has filled to a programmable alarm level.

The register port has three locations. Address 0 is the control/status register. Address 1 is the next-character register, which is read-only. Address 2 is the alarm level.

Top module: `rx_silo`

## Requirements
- R1: After reset the silo is empty, address 1 reads 0x0000, the control/status register reads 0x0000, the alarm level reads 16 and rx_irq is low.
- R2: A valid next-character word has these fields. Bit 15 is 1. Bit 14 is overrun. Bit 13 is the framing error (break) from the line. Bit 12 is the parity error from the line. Bits 11:8 hold the source line number. Bits 7:0 hold the character.
- R3: Reading address 1 with reg_rd high returns the head word combinationally and removes it at the clock edge. Words come out in the order they were stored. A character strobed before clock edge k, with no lower-numbered line waiting, can be read after edge k+1.
- R4: When several lines hold characters, one word is stored per cycle, lowest line number first. Characters strobed in the same cycle are read in ascending line order.
- R5: The silo holds 64 words. A character picked while the silo is full is discarded. The next word stored after that, whenever it arrives, carries overrun bit 14.
- R6: A read of address 1 while the silo is empty returns 0x0000 (bit 15 clear) and does not change the contents.
- R7: A strobe on a line whose holding register is occupied and not being moved that cycle discards the new character. The held character is later stored with overrun bit 14 set.
- R8: rx_irq is high exactly while control bit 6 (receive interrupt enable) is 1 and the fill count is greater than or equal to the alarm level. It falls as soon as a read takes the count below the level.
- R9: Writes to address 0 keep only bits 13, 12 and 6 (mask 0x3040, octal 030100), and the other bits read 0. Writes to address 2 set the alarm level, which reads back zero-extended. Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 16 | Per-line one-cycle character strobe |
| line_data | input | 128 | Per-line received byte, line i in bits 8i+7:8i |
| line_perr | input | 16 | Per-line parity error, qualified by the strobe |
| line_ferr | input | 16 | Per-line framing error, qualified by the strobe |
| reg_addr | input | 2 | Register address: 0 control/status, 1 next character, 2 alarm level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; at address 1 it removes the head word |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| rx_irq | output | 1 | Receive alarm interrupt, level |

## Verification
On every cycle the assertions check four things. The picker grants at most one line, and that line is the lowest one requesting. A grant never falls on an empty holding register. The silo count never passes its depth, and an empty silo stays empty when a read arrives with no write. An occupied holding register marks overrun when another strobe hits it, and a word stored after a discard carries the overrun flag. The bench scenarios cover the rest: the field layout of each word, the ascending drain order of characters that arrive together, the exact cycle at which a character becomes readable, and the interrupt rising at the alarm level and falling after a read. They also show that the 65th character is lost when the silo is full, and that the overrun flag waits through a complete drain before it lands on the next stored word.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

    parameter int NLINES     = 16;
    parameter int DEPTH      = 64;
    parameter int CHAR_W     = 8;
    parameter int LINE_W     = 4;
    parameter int ALARM_INIT = 16;

    localparam logic [1:0] ADDR_CSR   = 2'd0;
    localparam logic [1:0] ADDR_NXCH  = 2'd1;
    localparam logic [1:0] ADDR_ALARM = 2'd2;

    localparam logic [15:0] CSR_EN_MASK = 16'o030100;
    localparam int          RIE_BIT     = 6;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } silo_ent_t;

    typedef struct packed {
        logic              valid;
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] ch;
    } hold_t;

    function automatic logic [15:0] ent_to_word(input silo_ent_t e);
        return {1'b1, e};
    endfunction

endpackage

// File: rtl/rx_line_hold.sv
module rx_line_hold
    import rx_silo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [CHAR_W-1:0] ch,
    input  logic              perr,
    input  logic              ferr,
    input  logic              grant,
    output hold_t             q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (grant || !q.valid) begin
            q.valid <= stb;
            q.ovr   <= 1'b0;
            q.ferr  <= ferr;
            q.perr  <= perr;
            q.ch    <= ch;
        end else if (stb) begin
            q.ovr <= 1'b1;
        end
    end

    p_hold_ovr_r7: assert property (@(posedge clk) disable iff (rst)
        (q.valid && !grant && stb) |=> (q.valid && q.ovr));

    p_grant_valid_r4: assert property (@(posedge clk) disable iff (rst)
        grant |-> q.valid);

endmodule

// File: rtl/rx_arbiter.sv
module rx_arbiter
    import rx_silo_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      req,
    output logic [N-1:0]      grant,
    output logic [LINE_W-1:0] idx,
    output logic              any
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = LINE_W'(i);
        end
        any   = |req;
        grant = any ? (N'(1) << idx) : '0;
    end

    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_grant_lowest_r4: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> (((grant & req) != '0) && ((req & (grant - N'(1))) == '0)));

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import rx_silo_pkg::*;
#(
    parameter int D = DEPTH,
    localparam int PTR_W = $clog2(D),
    localparam int CNT_W = $clog2(D + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  silo_ent_t        wdata,
    input  logic             rd,
    output silo_ent_t        head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    silo_ent_t        mem [D];
    logic [PTR_W-1:0] wp, rp;
    logic             do_wr, do_rd;

    assign full  = (count == CNT_W'(D));
    assign empty = (count == '0);
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign head  = mem[rp];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(D - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= bump(wp);
            if (do_rd) rp <= bump(rp);
            count <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(D));

    p_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (rd && empty && !wr) |=> empty);

endmodule

// File: rtl/rx_silo.sv
module rx_silo
    import rx_silo_pkg::*;
#(
    parameter int N         = NLINES,
    parameter int D         = DEPTH,
    parameter int ALARM_RST = ALARM_INIT,
    localparam int CNT_W    = $clog2(D + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        line_stb,
    input  logic [N*CHAR_W-1:0] line_data,
    input  logic [N-1:0]        line_perr,
    input  logic [N-1:0]        line_ferr,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    output logic                rx_irq
);

    hold_t             hq [N];
    logic [N-1:0]      req, grant;
    logic [LINE_W-1:0] sel;
    logic              pick;
    silo_ent_t         wr_ent, head;
    logic [CNT_W-1:0]  count;
    logic              full, empty, wr_en, pop;
    logic              ovr_pend;
    logic [15:0]       csr_q;
    logic [CNT_W-1:0]  alarm_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        rx_line_hold u_hold (
            .clk   (clk),
            .rst   (rst),
            .stb   (line_stb[g]),
            .ch    (line_data[g*CHAR_W +: CHAR_W]),
            .perr  (line_perr[g]),
            .ferr  (line_ferr[g]),
            .grant (grant[g]),
            .q     (hq[g])
        );
        assign req[g] = hq[g].valid;
    end

    rx_arbiter #(.N(N)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .grant (grant),
        .idx   (sel),
        .any   (pick)
    );

    always_comb begin
        wr_ent.ovr  = hq[sel].ovr | ovr_pend;
        wr_ent.ferr = hq[sel].ferr;
        wr_ent.perr = hq[sel].perr;
        wr_ent.line = sel;
        wr_ent.ch   = hq[sel].ch;
    end

    assign wr_en = pick && !full;
    assign pop   = reg_rd && (reg_addr == ADDR_NXCH);

    rx_fifo #(.D(D)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_en),
        .wdata (wr_ent),
        .rd    (pop),
        .head  (head),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_pend <= 1'b0;
            csr_q    <= '0;
            alarm_q  <= CNT_W'(ALARM_RST);
        end else begin
            if (pick && full) ovr_pend <= 1'b1;
            else if (wr_en)   ovr_pend <= 1'b0;
            if (reg_wr && reg_addr == ADDR_CSR)   csr_q   <= reg_wdata & CSR_EN_MASK;
            if (reg_wr && reg_addr == ADDR_ALARM) alarm_q <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CSR:   reg_rdata = csr_q;
            ADDR_NXCH:  reg_rdata = empty ? 16'h0000 : ent_to_word(head);
            ADDR_ALARM: reg_rdata = 16'(alarm_q);
            default:    reg_rdata = 16'h0000;
        endcase
    end

    assign rx_irq = csr_q[RIE_BIT] && (count >= alarm_q);

    p_ovr_after_drop_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(pick && full) && wr_en) |-> wr_ent.ovr);

    p_empty_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |-> (reg_rdata == 16'h0000));

endmodule

// File: tb/rx_silo_tb.sv
module rx_silo_tb;

    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  line_stb;
    logic [N*8-1:0] line_data;
    logic [N-1:0]  line_perr, line_ferr;
    logic [1:0]    reg_addr;
    logic          reg_wr, reg_rd;
    logic [15:0]   reg_wdata, reg_rdata;
    logic          rx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [15:0] exp_q [$];

    always #4 clk = ~clk;

    rx_silo u_dut (
        .clk(clk), .rst(rst), .line_stb(line_stb), .line_data(line_data),
        .line_perr(line_perr), .line_ferr(line_ferr), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_irq(rx_irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] mkw(input logic ovr, input logic fe, input logic pe,
                                        input logic [3:0] ln, input logic [7:0] ch);
        return {1'b1, ovr, fe, pe, ln, ch};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        reg_rd   = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: strobe all lines in mask in one cycle, data = base + line
    task automatic send(input logic [N-1:0] mask, input logic [7:0] base,
                        input logic pe, input logic fe, input logic expect_it);
        for (int i = 0; i < N; i++) begin
            line_data[i*8 +: 8] = base + 8'(i);
            line_perr[i] = pe;
            line_ferr[i] = fe;
            if (mask[i] && expect_it) exp_q.push_back(mkw(1'b0, fe, pe, 4'(i), base + 8'(i)));
        end
        line_stb = mask;
        @(negedge clk);
        line_stb = '0;
    endtask

    // Monitor: pop words until bit 15 clears, comparing with scoreboard
    task automatic drain(input string tag);
        logic [15:0] v;
        for (int k = 0; k < 80; k++) begin
            rd_reg(2'd1, v);
            if (!v[15]) break;
            if (exp_q.size() == 0) check(tag, v, 16'h0000);
            else check(tag, v, exp_q.pop_front());
        end
        check({tag, " leftover"}, 16'(exp_q.size()), 16'd0);
        exp_q.delete();
    endtask

    logic [15:0] v;

    initial begin
        rst = 1'b1; line_stb = '0; line_data = '0; line_perr = '0; line_ferr = '0;
        reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_addr = 2'd0; #1 check("R1 csr", reg_rdata, 16'h0000);
        reg_addr = 2'd2; #1 check("R1 alarm", reg_rdata, 16'd16);
        check("R1 irq", 16'(rx_irq), 16'd0);
        @(negedge clk);
        rd_reg(2'd1, v); check("R1 R6 empty read", v, 16'h0000);

        // R2/R3 single char with parity error, exact latency
        send(16'h0020, 8'hA0, 1'b1, 1'b0, 1'b0);
        reg_addr = 2'd1; #1 check("R3 not yet visible", reg_rdata, 16'h0000);
        @(negedge clk);
        rd_reg(2'd1, v); check("R2 R3 parity word", v, mkw(1'b0, 1'b0, 1'b1, 4'd5, 8'hA5));
        rd_reg(2'd1, v); check("R3 popped", v, 16'h0000);

        // R2 framing error on line 15
        send(16'h8000, 8'h30, 1'b0, 1'b1, 1'b1);
        idle(1);
        drain("R2 framing");

        // R4 simultaneous lines 9, 3, 0
        send(16'h0209, 8'h10, 1'b0, 1'b0, 1'b1);
        idle(4);
        drain("R4 order");

        // R9 register writes
        wr_reg(2'd0, 16'hFFFF);
        rd_reg(2'd0, v); check("R9 csr mask", v, 16'h3040);
        wr_reg(2'd2, 16'd4);
        rd_reg(2'd2, v); check("R9 alarm rw", v, 16'd4);
        wr_reg(2'd1, 16'hBEEF);
        rd_reg(2'd1, v); check("R9 R6 nxch write ignored", v, 16'h0000);
        wr_reg(2'd0, 16'h0040);

        // R8 interrupt level
        for (int i = 0; i < 3; i++) send(16'h0004, 8'(8'h40 + 8'(i)), 1'b0, 1'b0, 1'b1);
        idle(2);
        check("R8 irq below level", 16'(rx_irq), 16'd0);
        send(16'h0004, 8'h50, 1'b0, 1'b0, 1'b1);
        idle(1);
        check("R8 irq at level", 16'(rx_irq), 16'd1);
        rd_reg(2'd1, v); check("R8 R3 first of four", v, exp_q.pop_front());
        check("R8 irq falls", 16'(rx_irq), 16'd0);
        wr_reg(2'd0, 16'h0000);
        drain("R8 rest");

        // R7 holding register overrun on line 3
        send(16'h000F, 8'h30, 1'b0, 1'b0, 1'b0);
        line_data[3*8 +: 8] = 8'h77;
        send(16'h0008, 8'h70, 1'b0, 1'b0, 1'b0);
        exp_q.push_back(mkw(1'b0, 1'b0, 1'b0, 4'd0, 8'h30));
        exp_q.push_back(mkw(1'b0, 1'b0, 1'b0, 4'd1, 8'h31));
        exp_q.push_back(mkw(1'b0, 1'b0, 1'b0, 4'd2, 8'h32));
        exp_q.push_back(mkw(1'b1, 1'b0, 1'b0, 4'd3, 8'h33));
        idle(4);
        drain("R7 hold overrun");

        // R5 full silo: 64 stored, 65th dropped, next stored word flagged
        wr_reg(2'd0, 16'h0040);
        for (int i = 0; i < 64; i++) send(16'h0002, 8'(i), 1'b0, 1'b0, 1'b1);
        send(16'h0002, 8'hEE, 1'b0, 1'b0, 1'b0);
        idle(3);
        check("R5 R8 irq when full", 16'(rx_irq), 16'd1);
        drain("R5 full contents");
        send(16'h0100, 8'h00, 1'b0, 1'b0, 1'b0);
        exp_q.push_back(mkw(1'b1, 1'b0, 1'b0, 4'd8, 8'h08));
        idle(1);
        drain("R5 overrun flag");
        rd_reg(2'd1, v); check("R6 empty after drain", v, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule